// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a CPU-side request port and a downstream memory port. Two address windows, each 32 MiB wide, act as alias views of two backing regions. Every 32-bit word in a window stands for one bit of the backing memory. A read in a window returns that single bit. A write in a window sets or clears that single bit and leaves every other bit of the backing memory untouched.

On each claimed access, the bridge computes the backing byte address and the index of the bit inside the fetched bytes, then reads the backing memory. For a read it returns the chosen bit. For a write it modifies that bit in the fetched data and writes the same group of bytes back. The bridge accepts no new upstream request until the write-back has completed, so the read-modify-write is atomic as seen from the CPU side.

The downstream port uses a 32-bit little-endian data bus. Byte lanes follow the low address bits, and byte strobes mark the lanes being written. Errors from the downstream port are passed back on the upstream response.

Top module: `bitband_bridge`

## Requirements
- R1: An access claimed in window 0 (`0x22000000`–`0x23FFFFFF`) reaches backing base `0x20000000`, and one in window 1 (`0x42000000`–`0x43FFFFFF`) reaches backing base `0x40000000`. The backing byte address is the base ORed with the low 25 address bits shifted right by 5, rounded down to a multiple of the access size.
- R2: `up_req_size` encodes the access size: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes. Size code 3 is never claimed. Each downstream request carries an address aligned to the size, and strobes that cover exactly those size bytes on lanes starting at address bits [1:0].
- R3: The bit index is (low 25 address bits >> 2) masked with (8 × size − 1). Its upper bits select the byte and its low three bits select the bit, with byte 0 as the lowest address. A read responds with that bit in `up_rsp_rdata[0]` and zero in bits 31:1.
- R4: A write reads the backing group first. It then writes the group back with the chosen bit equal to `up_req_wdata[0]` and all other bits unchanged. Bits 31:1 of the write data have no effect.
- R5: While `bb_enable` is low, nothing is claimed: `up_hit` and `up_req_ready` stay low and no downstream request is issued.
- R6: From acceptance until its response, `up_req_ready` stays low. A write issues exactly one downstream read followed by one downstream write.
- R7: An error on the downstream read gives `up_rsp_err` = 1. For a write, no write-back is issued.
- R8: An error on the downstream write-back gives `up_rsp_err` = 1 on the write response.
- R9: Addresses outside both windows are not claimed.
- R10: The response is a one-cycle `up_rsp_valid` pulse. Downstream request fields stay stable while `dn_req_valid` is high and `dn_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bb_enable | input | 1 | Enables both alias windows |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted this cycle |
| up_req_addr | input | 32 | Upstream alias address |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_size | input | 2 | Access size code |
| up_req_wdata | input | 32 | Write data, bit 0 used |
| up_hit | output | 1 | Current request falls in an enabled window |
| up_rsp_valid | output | 1 | Response pulse |
| up_rsp_rdata | output | 32 | Read bit in bit 0 |
| up_rsp_err | output | 1 | Response carries an error |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_addr | output | 32 | Downstream byte address |
| dn_req_write | output | 1 | Downstream write |
| dn_req_wdata | output | 32 | Downstream write data |
| dn_req_strb | output | 4 | Downstream byte strobes |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_rdata | input | 32 | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error |

## Verification
The bench builds the bridge with its default windows and bases. It keeps alias offsets below 8 KiB, so every access falls in the first 256 backing bytes, which a 64-word model memory holds whole. Within that range it sweeps all three sizes in both windows over a dense stride of offsets, with varied ignored low address bits. This reaches every byte lane, every strobe pattern, and every alignment rounding. Injected read and write-back errors, a stalling downstream ready, disabled and out-of-window addresses, and size code 3 complete the set.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int          AW       = 32,
  parameter int          WIN_LOG2 = 25,
  parameter logic [31:0] ALIAS0   = 32'h2200_0000,
  parameter logic [31:0] BACK0    = 32'h2000_0000,
  parameter logic [31:0] ALIAS1   = 32'h4200_0000,
  parameter logic [31:0] BACK1    = 32'h4000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bb_enable,
  input  logic          up_req_valid,
  output logic          up_req_ready,
  input  logic [AW-1:0] up_req_addr,
  input  logic          up_req_write,
  input  logic [1:0]    up_req_size,
  input  logic [31:0]   up_req_wdata,
  output logic          up_hit,
  output logic          up_rsp_valid,
  output logic [31:0]   up_rsp_rdata,
  output logic          up_rsp_err,
  output logic          dn_req_valid,
  input  logic          dn_req_ready,
  output logic [AW-1:0] dn_req_addr,
  output logic          dn_req_write,
  output logic [31:0]   dn_req_wdata,
  output logic [3:0]    dn_req_strb,
  input  logic          dn_rsp_valid,
  input  logic [31:0]   dn_rsp_rdata,
  input  logic          dn_rsp_err
);
  localparam int TOPW = AW - WIN_LOG2;

  typedef enum logic [2:0] {S_IDLE, S_RREQ, S_RRSP, S_WREQ, S_WRSP, S_DONE} st_t;
  st_t st;

  logic [WIN_LOG2-1:0] off;
  logic                in0, in1;
  logic [AW-1:0]       raw, aligned;
  logic [1:0]          lowmask;
  logic [4:0]          idx;
  logic [3:0]          strb_n;

  assign off     = up_req_addr[WIN_LOG2-1:0];
  assign in0     = up_req_addr[AW-1:WIN_LOG2] == ALIAS0[AW-1:WIN_LOG2];
  assign in1     = up_req_addr[AW-1:WIN_LOG2] == ALIAS1[AW-1:WIN_LOG2];
  assign up_hit  = bb_enable && (in0 || in1) && (up_req_size != 2'd3);
  assign raw     = (in0 ? BACK0[AW-1:0] : BACK1[AW-1:0]) | ({{TOPW{1'b0}}, off} >> 5);
  assign lowmask = (up_req_size == 2'd0) ? 2'b00 : (up_req_size == 2'd1) ? 2'b01 : 2'b11;
  assign aligned = {raw[AW-1:2], raw[1:0] & ~lowmask};
  assign idx     = {off[6] & up_req_size[1], off[5] & (up_req_size != 2'd0), off[4:2]};
  assign strb_n  = (up_req_size == 2'd0) ? 4'b0001 : (up_req_size == 2'd1) ? 4'b0011 : 4'b1111;

  logic [AW-1:0] q_addr;
  logic [3:0]    q_strb;
  logic [4:0]    q_bit;
  logic [1:0]    q_mask;
  logic          q_wr, q_val, r_bit, r_err;
  logic [31:0]   wbuf;

  assign up_req_ready = (st == S_IDLE) && up_hit;
  assign dn_req_valid = (st == S_RREQ) || (st == S_WREQ);
  assign dn_req_write = (st == S_WREQ);
  assign dn_req_addr  = q_addr;
  assign dn_req_strb  = q_strb;
  assign dn_req_wdata = wbuf;
  assign up_rsp_valid = (st == S_DONE);
  assign up_rsp_rdata = {31'd0, r_bit};
  assign up_rsp_err   = r_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      q_addr <= '0; q_strb <= '0; q_bit <= '0; q_mask <= '0;
      q_wr <= 1'b0; q_val <= 1'b0; r_bit <= 1'b0; r_err <= 1'b0; wbuf <= '0;
    end else begin
      case (st)
        S_IDLE: if (up_req_valid && up_hit) begin
          q_addr <= aligned;
          q_strb <= strb_n << aligned[1:0];
          q_bit  <= {aligned[1:0], 3'b000} + idx;
          q_mask <= lowmask;
          q_wr   <= up_req_write;
          q_val  <= up_req_wdata[0];
          st     <= S_RREQ;
        end
        S_RREQ: if (dn_req_ready) st <= S_RRSP;
        S_RRSP: if (dn_rsp_valid) begin
          if (dn_rsp_err) begin
            r_err <= 1'b1; r_bit <= 1'b0; st <= S_DONE;
          end else if (q_wr) begin
            wbuf        <= dn_rsp_rdata;
            wbuf[q_bit] <= q_val;
            st          <= S_WREQ;
          end else begin
            r_err <= 1'b0; r_bit <= dn_rsp_rdata[q_bit]; st <= S_DONE;
          end
        end
        S_WREQ: if (dn_req_ready) st <= S_WRSP;
        S_WRSP: if (dn_rsp_valid) begin
          r_err <= dn_rsp_err; r_bit <= 1'b0; st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> !up_req_ready); // R6
  AST_READ_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |-> (up_rsp_rdata[31:1] == 31'd0)); // R3
  AST_DN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> ((dn_req_addr[1:0] & q_mask) == 2'b00)); // R2
  AST_STRB_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> ($countones(dn_req_strb) == 32'(q_mask) + 1)); // R2
  AST_RD_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RRSP && dn_rsp_valid && dn_rsp_err) |=> !dn_req_valid); // R7
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_write))); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |=> !up_rsp_valid); // R10
endmodule

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;
  logic clk = 1'b0, rst_n = 1'b0, bb_enable = 1'b1;
  logic up_req_valid = 1'b0, up_req_write = 1'b0;
  logic [31:0] up_req_addr = '0, up_req_wdata = '0;
  logic [1:0] up_req_size = '0;
  logic up_req_ready, up_hit, up_rsp_valid, up_rsp_err;
  logic [31:0] up_rsp_rdata;
  logic dn_req_valid, dn_req_write, dn_req_ready = 1'b0;
  logic [31:0] dn_req_addr, dn_req_wdata;
  logic [3:0] dn_req_strb;
  logic dn_rsp_valid = 1'b0, dn_rsp_err = 1'b0;
  logic [31:0] dn_rsp_rdata = '0;

  always #4 clk = ~clk;

  bitband_bridge dut (.*);

  int tests = 0, fails = 0, cycles = 0;
  logic [31:0] mem [64];
  logic [31:0] exp_mem [64];
  int rd_err_word = -1, wr_err_word = -1;
  int n_rd = 0, n_wr = 0, rdy_cnt = 0;
  logic [31:0] exp_addr;
  logic [3:0] exp_strb;
  logic last_was_rd = 1'b0;
  logic pend = 1'b0, pend_err = 1'b0;
  logic [31:0] pend_data = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (pend) begin
      dn_rsp_valid = 1'b1; dn_rsp_rdata = pend_data; dn_rsp_err = pend_err; pend = 1'b0;
    end else begin
      dn_rsp_valid = 1'b0; dn_rsp_rdata = 32'hDEAD_BEEF; dn_rsp_err = 1'b0;
    end
    rdy_cnt++;
    dn_req_ready = (rdy_cnt % 3) != 1;
    if (rst_n && dn_req_valid && dn_req_ready) begin
      chk(dn_req_addr == exp_addr, "R1", dn_req_addr, exp_addr);
      chk(dn_req_strb == exp_strb, "R2", {28'd0, dn_req_strb}, {28'd0, exp_strb});
      pend = 1'b1;
      if (!dn_req_write) begin
        n_rd++;
        last_was_rd = 1'b1;
        pend_err  = (int'(dn_req_addr[7:2]) == rd_err_word);
        pend_data = mem[dn_req_addr[7:2]];
      end else begin
        n_wr++;
        chk(last_was_rd, "R6", {31'd0, last_was_rd}, 32'd1);
        last_was_rd = 1'b0;
        pend_err  = (int'(dn_req_addr[7:2]) == wr_err_word);
        pend_data = 32'h0;
        if (!pend_err)
          for (int b = 0; b < 4; b++)
            if (dn_req_strb[b]) mem[dn_req_addr[7:2]][8*b +: 8] = dn_req_wdata[8*b +: 8];
      end
    end
  end

  function automatic logic [31:0] bk_addr(input logic [31:0] a, input int sz);
    logic [31:0] base, r;
    int n;
    base = (a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
    n = 1 << sz;
    r = base | ({7'd0, a[24:0]} >> 5);
    return r - (r % n);
  endfunction

  function automatic int bit_pos(input logic [31:0] a, input int sz);
    return int'(a[24:2]) % (8 << sz);
  endfunction

  task automatic access(input logic [31:0] a, input logic wr, input int sz, input logic [31:0] wd,
                        output logic claimed, output logic rbit, output logic err);
    int guard;
    @(negedge clk);
    up_req_addr = a; up_req_write = wr; up_req_size = 2'(sz); up_req_wdata = wd; up_req_valid = 1'b1;
    if (sz < 3) begin
      exp_addr = bk_addr(a, sz);
      exp_strb = 4'(((1 << (1 << sz)) - 1) << exp_addr[1:0]);
    end
    #1;
    claimed = up_req_ready; rbit = 1'b0; err = 1'b0;
    if (!claimed) begin
      @(negedge clk); #1;
      up_req_valid = 1'b0;
      return;
    end
    guard = 0;
    forever begin
      @(negedge clk); #1;
      guard++;
      if (up_rsp_valid) begin
        rbit = up_rsp_rdata[0]; err = up_rsp_err;
        chk(up_rsp_rdata[31:1] == 31'd0, "R3", up_rsp_rdata, {31'd0, rbit});
        break;
      end
      if (up_req_ready) chk(1'b0, "R6", 32'd1, 32'd0);
      if (guard > 50) break;
    end
    up_req_valid = 1'b0;
    @(negedge clk); #1;
    chk(!up_rsp_valid, "R10", {31'd0, up_rsp_valid}, 32'd0);
  endtask

  initial begin
    logic c, rb, er, eb;
    logic [31:0] a, bk;
    int bp, by, w, rd0, wr0;
    for (int i = 0; i < 64; i++) begin
      mem[i] = (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_1234;
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    #1;
    chk(!up_rsp_valid && !dn_req_valid && !up_req_ready, "R10", {29'd0, up_rsp_valid, dn_req_valid, up_req_ready}, 32'd0);
    rst_n = 1'b1;

    for (int r = 0; r < 2; r++)
      for (int sz = 0; sz < 3; sz++)
        for (int k = 0; k < 2048; k += 5) begin
          a = (r == 0 ? 32'h2200_0000 : 32'h4200_0000) + 32'(k * 4 + (k % 4));
          bk = bk_addr(a, sz); bp = bit_pos(a, sz);
          by = int'(bk[7:0]) + bp / 8;
          eb = exp_mem[by / 4][(by % 4) * 8 + bp % 8];
          access(a, 1'b0, sz, 32'h0, c, rb, er);
          chk(c && !er && rb == eb, "R3", {30'd0, c, rb}, {30'd1, eb});
          eb = 1'(((k * 7) >> 2) & 1);
          access(a, 1'b1, sz, 32'hFFFF_FFFE | {31'd0, eb}, c, rb, er);
          exp_mem[by / 4][(by % 4) * 8 + bp % 8] = eb;
          chk(c && !er && mem[by / 4] == exp_mem[by / 4], "R4", mem[by / 4], exp_mem[by / 4]);
        end
    for (int i = 0; i < 64; i++) chk(mem[i] == exp_mem[i], "R4", mem[i], exp_mem[i]);

    a = 32'h4200_0104; bk = bk_addr(a, 2); w = int'(bk[7:2]);
    rd_err_word = w; rd0 = n_rd; wr0 = n_wr;
    access(a, 1'b1, 2, 32'h1, c, rb, er);
    chk(er && n_wr == wr0 && n_rd == rd0 + 1, "R7", {31'd0, er}, 32'd1);
    chk(mem[w] == exp_mem[w], "R7", mem[w], exp_mem[w]);
    access(a, 1'b0, 2, 32'h0, c, rb, er);
    chk(er && rb == 1'b0, "R7", {30'd0, er, rb}, 32'd2);
    rd_err_word = -1; wr_err_word = w;
    access(a, 1'b1, 1, 32'h1, c, rb, er);
    chk(er && n_wr == wr0 + 1, "R8", {31'd0, er}, 32'd1);
    wr_err_word = -1;

    rd0 = n_rd; wr0 = n_wr;
    bb_enable = 1'b0;
    access(32'h2200_0040, 1'b1, 0, 32'h1, c, rb, er);
    chk(!c && !up_hit, "R5", {30'd0, c, up_hit}, 32'd0);
    access(32'h4200_0040, 1'b0, 2, 32'h0, c, rb, er);
    chk(!c, "R5", {31'd0, c}, 32'd0);
    bb_enable = 1'b1;
    access(32'h2400_0000, 1'b1, 0, 32'h1, c, rb, er);
    chk(!c, "R9", {31'd0, c}, 32'd0);
    access(32'h21FF_FFFC, 1'b0, 0, 32'h0, c, rb, er);
    chk(!c, "R9", {31'd0, c}, 32'd0);
    access(32'h6200_0000, 1'b0, 0, 32'h0, c, rb, er);
    chk(!c, "R9", {31'd0, c}, 32'd0);
    access(32'h2200_0040, 1'b0, 3, 32'h0, c, rb, er);
    chk(!c, "R2", {31'd0, c}, 32'd0);
    chk(n_rd == rd0 && n_wr == wr0, "R5", 32'(n_rd - rd0 + n_wr - wr0), 32'd0);
    for (int i = 0; i < 64; i++) chk(mem[i] == exp_mem[i], "R5", mem[i], exp_mem[i]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule